// File: doc/BRIEF.md
# Ling pseudo-carry adder

A two-operand binary adder, 64 bits wide by default, whose carry network carries Ling pseudo-carries and not true carries. Each bit position forms a generate term (both operand bits set) and a transmit term (either operand bit set). The bits are gathered into groups of four. Each group reduces its bits to one pseudo-generate and one group transmit. Because of the Ling form, the first combining level needs fewer series terms than a conventional carry-lookahead group. A parallel prefix tree over the groups then builds the long-range pseudo-carry at every group boundary.

True carries are never routed through the tree. At each group boundary the true carry is recovered as the transmit bit just below the boundary ANDed with the pseudo-carry there. That recovered carry selects one of two sums that the group has already prepared, one for each value of the incoming carry. The carry-in enters the network as an extra generate one position below bit 0. The carry-out is the recovered true carry above the top bit. The block is purely combinational and has no clock or state.

Top module: `ling_adder`

## Requirements
- R1: `sum` equals the low W bits of a + b + cin, for any operands and carry-in.
- R2: `cout` equals bit W (the bit just above the top) of a + b + cin.
- R3: When every bit position transmits and none generates (b equal to the bitwise inverse of a), cin = 0 gives a sum of all ones with `cout` = 0, and cin = 1 gives a sum of zero with `cout` = 1.
- R4: For a whose low k bits are ones and all other bits zero, with b = 1 and cin = 0, for every k from 1 to W: the sum is 2^k and `cout` is 0 for k < W, and the sum is zero with `cout` = 1 for k = W. This carries a run across every four-bit group boundary.
- R5: When both operands are all ones, `cout` is 1 and the sum is all ones except bit 0, which equals cin.
- R6: When both operands are zero, `cout` is 0 and the sum is cin in bit 0, with all other bits zero.
- R7: With b equal to the inverse of a except at one position k where both operand bits are 1, and cin = 0, the sum has ones in bits below k and zeros in bit k and above, and `cout` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | W (64) | First operand |
| b | input | W (64) | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | W (64) | Low W bits of the total |
| cout | output | 1 | Carry out of the top bit |

## Verification
The block has no state, so a wrong pseudo-carry anywhere in the prefix tree shows up at once as a wrong sum in the group that this boundary's carry selects. Usually the upper groups show it too, and `cout` shows it whenever the error reaches the top. A wrong term in the group reduction appears only for operand patterns that exercise that term. For that reason the bench applies long transmit runs, isolated generates and carry runs of every length next to the random vectors. Each vector is compared in the same cycle in which it is applied.

// File: rtl/ling_pkg.sv
package ling_pkg;

    localparam int GRP = 4;

    typedef struct packed {
        logic h;
        logic t;
    } lpair_t;

    function automatic lpair_t lmerge(lpair_t hi, lpair_t lo);
        lpair_t r;
        r.h = hi.h | (hi.t & lo.h);
        r.t = hi.t & lo.t;
        return r;
    endfunction

    function automatic logic grp_h(logic [GRP-1:0] g, logic [GRP-1:0] t);
        return g[3] | g[2] | (t[2] & g[1]) | (t[2] & t[1] & g[0]);
    endfunction

    function automatic logic grp_t(logic [GRP-1:0] t, logic tprev);
        return t[2] & t[1] & t[0] & tprev;
    endfunction

endpackage

// File: rtl/ling_leaf.sv
module ling_leaf
    import ling_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [W-1:0]              a,
    input  logic [W-1:0]              b,
    output lpair_t [W/GRP-1:0]        leaf,
    output logic   [W/GRP-1:0]        tend
);
    localparam int NG = W / GRP;

    logic [W-1:0] gv;
    logic [W-1:0] tv;

    assign gv = a & b;
    assign tv = a | b;

    genvar j;
    generate
        for (j = 0; j < NG; j++) begin : g_grp
            logic tprev;
            if (j == 0) begin : g_first
                assign tprev = 1'b1;
            end else begin : g_rest
                assign tprev = tv[j*GRP-1];
            end
            assign leaf[j].h = grp_h(gv[j*GRP +: GRP], tv[j*GRP +: GRP]);
            assign leaf[j].t = grp_t(tv[j*GRP +: GRP], tprev);
            assign tend[j]   = tv[j*GRP+GRP-1];
        end
    endgenerate

endmodule

// File: rtl/ling_tree.sv
module ling_tree
    import ling_pkg::*;
#(
    parameter int NG = 16
) (
    input  lpair_t [NG-1:0] leaf,
    output lpair_t [NG-1:0] pre
);
    localparam int LV = $clog2(NG);

    lpair_t [NG-1:0] lvl [LV+1];

    assign lvl[0] = leaf;

    genvar s, i;
    generate
        for (s = 0; s < LV; s++) begin : g_lvl
            localparam int D = 1 << s;
            for (i = 0; i < NG; i++) begin : g_node
                if (i >= D) begin : g_mrg
                    assign lvl[s+1][i] = lmerge(lvl[s][i], lvl[s][i-D]);
                end else begin : g_pass
                    assign lvl[s+1][i] = lvl[s][i];
                end
            end
        end
    endgenerate

    assign pre = lvl[LV];

endmodule

// File: rtl/ling_csel.sv
module ling_csel
    import ling_pkg::*;
(
    input  logic [GRP-1:0] a4,
    input  logic [GRP-1:0] b4,
    input  logic           sel,
    output logic [GRP-1:0] s4
);
    logic [GRP-1:0] s_zero;
    logic [GRP-1:0] s_one;

    assign s_zero = a4 + b4;
    assign s_one  = a4 + b4 + GRP'(1);
    assign s4     = sel ? s_one : s_zero;

endmodule

// File: rtl/ling_adder.sv
module ling_adder
    import ling_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    localparam int NG = W / GRP;

    lpair_t [NG-1:0] leaf;
    lpair_t [NG-1:0] pre;
    logic   [NG-1:0] tend;
    logic   [NG:0]   hcar;
    logic   [NG:0]   cgrp;

    ling_leaf #(.W(W)) u_leaf (
        .a    (a),
        .b    (b),
        .leaf (leaf),
        .tend (tend)
    );

    ling_tree #(.NG(NG)) u_tree (
        .leaf (leaf),
        .pre  (pre)
    );

    assign hcar[0] = cin;
    assign cgrp[0] = cin;

    genvar j;
    generate
        for (j = 0; j < NG; j++) begin : g_sel
            assign hcar[j+1] = pre[j].h | (pre[j].t & cin);
            assign cgrp[j+1] = tend[j] & hcar[j+1];
            ling_csel u_csel (
                .a4  (a[j*GRP +: GRP]),
                .b4  (b[j*GRP +: GRP]),
                .sel (cgrp[j]),
                .s4  (sum[j*GRP +: GRP])
            );
        end
    endgenerate

    assign cout = cgrp[NG];

endmodule

// File: rtl/ling_adder_chk.sv
module ling_adder_chk #(
    parameter int W = 64
) (
    input logic [W-1:0] a,
    input logic [W-1:0] b,
    input logic         cin,
    input logic [W-1:0] sum,
    input logic         cout
);
    logic [W:0] want;
    logic       known;

    always_comb begin
        want  = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
        known = !$isunknown({a, b, cin, sum, cout});
        if (known) begin
            // R1
            sum_value_chk: assert (sum == want[W-1:0]);
            // R2
            cout_value_chk: assert (cout == want[W]);
            // R3
            full_transmit_chk: assert (!((a ^ b) == {W{1'b1}})
                || (sum == {W{~cin}} && cout == cin));
            // R5
            all_generate_chk: assert (!((a & b) == {W{1'b1}})
                || (cout && sum[W-1:1] == {(W-1){1'b1}} && sum[0] == cin));
            // R6
            zero_operand_chk: assert (!(a == '0 && b == '0)
                || (!cout && sum == {{(W-1){1'b0}}, cin}));
        end
    end

endmodule

bind ling_adder ling_adder_chk #(.W(W)) u_chk (
    .a    (a),
    .b    (b),
    .cin  (cin),
    .sum  (sum),
    .cout (cout)
);

// File: tb/tb_ling_adder.sv
`timescale 1ns/1ps
module tb_ling_adder;
    localparam int W = 64;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;
    logic         cin = 1'b0;
    logic [W-1:0] sum;
    logic         cout;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    ling_adder #(.W(W)) dut (
        .a    (a),
        .b    (b),
        .cin  (cin),
        .sum  (sum),
        .cout (cout)
    );

    task automatic check(string req, logic [W-1:0] es, logic ec);
        n_chk++;
        if (sum !== es || cout !== ec) begin
            n_err++;
            $display("FAIL %s: actual cout=%0b sum=%h expected cout=%0b sum=%h",
                     req, cout, sum, ec, es);
        end
    endtask

    task automatic drive(logic [W-1:0] va, logic [W-1:0] vb, logic vc);
        @(posedge clk);
        a   <= va;
        b   <= vb;
        cin <= vc;
        @(negedge clk);
    endtask

    task automatic run_ref(string req, logic [W-1:0] va, logic [W-1:0] vb, logic vc);
        logic [W:0] r;
        drive(va, vb, vc);
        r = {1'b0, va} + {1'b0, vb} + {{W{1'b0}}, vc};
        check(req, r[W-1:0], r[W]);
    endtask

    task automatic run_exp(string req, logic [W-1:0] va, logic [W-1:0] vb, logic vc,
                           logic [W-1:0] es, logic ec);
        drive(va, vb, vc);
        check(req, es, ec);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst <= 1'b0;
        @(negedge clk);
        check("R6 reset state", '0, 1'b0);

        // R6 zero operands
        run_exp("R6", '0, '0, 1'b0, '0, 1'b0);
        run_exp("R6", '0, '0, 1'b1, 64'd1, 1'b0);

        // R3 all transmit, no generate
        run_exp("R3", 64'h0123_4567_89AB_CDEF, ~64'h0123_4567_89AB_CDEF, 1'b0, '1, 1'b0);
        run_exp("R3", 64'h0123_4567_89AB_CDEF, ~64'h0123_4567_89AB_CDEF, 1'b1, '0, 1'b1);
        run_exp("R3", '1, '0, 1'b1, '0, 1'b1);
        run_exp("R3", 64'hAAAA_AAAA_AAAA_AAAA, 64'h5555_5555_5555_5555, 1'b1, '0, 1'b1);

        // R5 both operands all ones
        run_exp("R5", '1, '1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFE, 1'b1);
        run_exp("R5", '1, '1, 1'b1, '1, 1'b1);

        // R4 carry run of every length
        for (int k = 1; k <= W; k++) begin
            logic [W:0] m;
            m = ({{W{1'b0}}, 1'b1} << k) - 1;
            if (k < W)
                run_exp("R4", m[W-1:0], 64'd1, 1'b0, m[W-1:0] + 64'd1, 1'b0);
            else
                run_exp("R4", m[W-1:0], 64'd1, 1'b0, '0, 1'b1);
        end

        // R7 single generate below a transmit run
        for (int k = 0; k < W; k++) begin
            logic [W-1:0] va, vb, lo;
            va = {$urandom, $urandom};
            vb = ~va;
            va[k] = 1'b1;
            vb[k] = 1'b1;
            lo = (64'd1 << k) - 64'd1;
            run_exp("R7", va, vb, 1'b0, lo, 1'b1);
        end

        // R1 R2 random and structured operands
        for (int i = 0; i < 2000; i++) begin
            logic [W-1:0] va, vb;
            va = {$urandom, $urandom};
            vb = {$urandom, $urandom};
            if (i % 4 == 1) vb = ~va ^ (64'd1 << (i % W));
            if (i % 4 == 2) va = va | vb;
            run_ref("R1 R2", va, vb, 1'($urandom));
        end
        run_ref("R1 R2", 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b0);
        run_ref("R1 R2", 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001, 1'b1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule